// File: doc/BRIEF.md
# LIN Bus Remote Wake-up Filter

This block decides when activity on a LIN bus counts as a remote wake-up while the transceiver sits in one of its low-power modes (silent or sleep). It samples the bus receiver level through a synchronizer. It looks for a recessive-to-dominant transition and then requires the dominant level to persist for a programmable number of clock cycles. Only then does it raise a wake-up request.

The mode controller tells the block whether a low-power mode is active and whether normal mode has been reached. A recognised wake-up produces a one-cycle request pulse for the mode controller, which then moves the device to pre-normal mode and restores the bus termination. It also sets a latched indication that pulls the receive-data pin low to interrupt the host. That indication is held until normal mode is reported.

The filter length is a parameter in clock cycles. The nominal target is 90 µs, and anything from 30 µs to 150 µs is acceptable. At a 200 MHz clock the default is 18000 cycles.

Top module: `lin_wake_filter`

## Requirements
- R1: Out of reset, `wake_req` and `rxd_low` are both 0.
- R2: With `low_pwr` high, bus level 1 = recessive and 0 = dominant, and `bus_rx` passing through a two-flop synchronizer: a wake-up fires when a falling edge is followed by `bus_rx` low for N = FILTER_CYCLES consecutive clock samples, counting the edge sample. `wake_req` is then high in the (N+2)-th cycle after the first low sample. Holding the bus low beyond N samples gives the same timing.
- R3: If the bus is dominant for fewer than N samples, no wake-up is reported. The count restarts from zero on the next falling edge, so a later dominant run must again reach N samples on its own.
- R4: `wake_req` is high for exactly one clock cycle per recognised wake-up.
- R5: While `low_pwr` is low, bus activity of any length produces no wake-up request.
- R6: If the bus is already dominant when `low_pwr` rises, no wake-up is reported however long it stays dominant. A fresh recessive-to-dominant edge is required.
- R7: `rxd_low` rises in the same cycle as `wake_req`. It stays high, even after `low_pwr` falls, until `normal_mode` is sampled high, and it is 0 in the cycle that follows.
- R8: If `low_pwr` falls while a dominant run is being timed, the run is abandoned and no request is issued.
- R9: After a wake-up, further bus activity produces no new request until `low_pwr` has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_rx | input | 1 | Raw bus receiver level, 1 = recessive, 0 = dominant |
| low_pwr | input | 1 | High while the transceiver is in silent or sleep mode |
| normal_mode | input | 1 | High while the transceiver is in normal mode |
| wake_req | output | 1 | One-cycle remote wake-up request |
| rxd_low | output | 1 | Latched wake indication, forces receive-data low |

## Verification
On every cycle, the bound checker enforces the following:
- the request is a single-cycle pulse;
- no request appears outside low-power mode;
- the indication rises only together with a request;
- the indication holds until normal mode and drops right after it.

The timing of detection needs the bench's scenarios. This covers the exact cycle a request appears for dominant runs of every length around the filter count, the restart of the count after a short dominant run, the refusal to fire on a bus already dominant at mode entry, and the abort when low-power mode ends mid-count.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_TIME  = 2'd2,
    ST_DONE  = 2'd3
  } lwf_state_t;
endpackage

// File: rtl/lwf_sync.sv
module lwf_sync #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/lwf_fall_det.sv
module lwf_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;
endmodule

// File: rtl/lwf_dom_timer.sv
module lwf_dom_timer #(
  parameter int FILTER_CYCLES = 18000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic term
);
  localparam int CW = (FILTER_CYCLES > 2) ? $clog2(FILTER_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILTER_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign term = (cnt_q == LAST);
endmodule

// File: rtl/lwf_ctrl.sv
module lwf_ctrl
  import lwf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_s,
  input  logic fall,
  input  logic low_pwr,
  input  logic normal_mode,
  input  logic term,
  output logic tmr_clr,
  output logic tmr_inc,
  output logic wake_req,
  output logic rxd_low
);
  lwf_state_t st_q, st_d;
  logic       fire;
  logic       req_d, ind_d;

  always_comb begin
    st_d    = st_q;
    tmr_clr = 1'b0;
    tmr_inc = 1'b0;
    fire    = 1'b0;
    if (!low_pwr) begin
      st_d    = ST_OFF;
      tmr_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_d    = ST_ARMED;
          tmr_clr = 1'b1;
        end
        ST_ARMED: begin
          if (fall) begin
            st_d    = ST_TIME;
            tmr_inc = 1'b1;
          end
        end
        ST_TIME: begin
          if (bus_s) begin
            st_d    = ST_ARMED;
            tmr_clr = 1'b1;
          end else if (term) begin
            st_d    = ST_DONE;
            tmr_clr = 1'b1;
            fire    = ~normal_mode;
          end else begin
            tmr_inc = 1'b1;
          end
        end
        ST_DONE: st_d = ST_DONE;
        default: st_d = ST_OFF;
      endcase
    end
    req_d = fire;
    ind_d = normal_mode ? 1'b0 : (fire | rxd_low);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OFF;
      wake_req <= 1'b0;
      rxd_low  <= 1'b0;
    end else begin
      st_q     <= st_d;
      wake_req <= req_d;
      rxd_low  <= ind_d;
    end
  end
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
  parameter int FILTER_CYCLES = 18000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rx,
  input  logic low_pwr,
  input  logic normal_mode,
  output logic wake_req,
  output logic rxd_low
);
  logic bus_s, fall, term, tmr_clr, tmr_inc;

  lwf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(bus_rx), .d_out(bus_s)
  );

  lwf_fall_det u_fall (
    .clk(clk), .rst_n(rst_n), .lvl(bus_s), .fall(fall)
  );

  lwf_dom_timer #(.FILTER_CYCLES(FILTER_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .term(term)
  );

  lwf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_s(bus_s), .fall(fall),
    .low_pwr(low_pwr), .normal_mode(normal_mode), .term(term),
    .tmr_clr(tmr_clr), .tmr_inc(tmr_inc),
    .wake_req(wake_req), .rxd_low(rxd_low)
  );
endmodule

// File: rtl/lwf_chk.sv
module lwf_chk (
  input logic clk,
  input logic rst_n,
  input logic low_pwr,
  input logic normal_mode,
  input logic wake_req,
  input logic rxd_low
);
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  // R5
  no_wake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !low_pwr |=> !wake_req);

  // R7
  ind_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> rxd_low);

  // R7
  ind_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxd_low) |-> wake_req);

  // R7
  ind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_low && !normal_mode) |=> rxd_low);

  // R7
  ind_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    normal_mode |=> !rxd_low);
endmodule

bind lin_wake_filter lwf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .low_pwr(low_pwr), .normal_mode(normal_mode),
  .wake_req(wake_req), .rxd_low(rxd_low)
);

// File: tb/tb_lin_wake_filter.sv
`timescale 1ns/100ps
module tb_lin_wake_filter;
  localparam int N = 6;

  logic clk, rst_n, bus_rx, low_pwr, normal_mode;
  logic wake_req, rxd_low;
  int   n_chk, n_bad, cyc;

  lin_wake_filter #(.FILTER_CYCLES(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_rx(bus_rx), .low_pwr(low_pwr),
    .normal_mode(normal_mode), .wake_req(wake_req), .rxd_low(rxd_low)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive dominant for d samples from a negedge; report hits and cycle of first hit.
  task automatic pulse(input int d, output int hits, output int at);
    hits = 0; at = -1;
    bus_rx = 1'b0;
    for (int k = 1; k <= d + N + 8; k++) begin
      @(negedge clk);
      if (wake_req) begin
        hits++;
        if (at < 0) at = k;
      end
      if (k == d) bus_rx = 1'b1;
    end
  endtask

  task automatic exp_pulse(input string tag, input int d, input bit fire);
    int h, a;
    pulse(d, h, a);
    check({tag, " hits"}, h, fire ? 1 : 0);
    if (fire) check({tag, " cycle"}, a, N + 2);
  endtask

  task automatic to_normal();
    low_pwr = 1'b0; normal_mode = 1'b1;
    idle(2);
    normal_mode = 1'b0;
    idle(2);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 20000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int h, a;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; bus_rx = 1'b1; low_pwr = 1'b0; normal_mode = 1'b0;
    idle(3);
    check("R1 wake_req", wake_req, 0);
    check("R1 rxd_low", rxd_low, 0);
    rst_n = 1'b1;
    idle(3);

    // R5: no detection outside low-power mode
    exp_pulse("R5 off", N + 4, 0);
    check("R5 rxd_low", rxd_low, 0);

    low_pwr = 1'b1;
    idle(4);
    // R3: sweep short runs
    for (int d = 1; d < N; d++) begin
      exp_pulse($sformatf("R3 short d=%0d", d), d, 0);
      idle(3);
    end
    check("R3 rxd_low", rxd_low, 0);

    // R3: short run, one recessive sample, then full run; count must restart
    bus_rx = 1'b0; idle(N - 1);
    bus_rx = 1'b1; idle(1);
    exp_pulse("R3 restart", N, 1);

    // R9: no second wake in same episode; R7 hold
    exp_pulse("R9 second", N + 3, 0);
    check("R7 held", rxd_low, 1);
    low_pwr = 1'b0;
    idle(5);
    check("R7 held in prenormal", rxd_low, 1);
    normal_mode = 1'b1;
    @(negedge clk);
    check("R7 cleared", rxd_low, 0);
    normal_mode = 1'b0;
    idle(2);

    // R2: sweep run lengths at and beyond N, with R4 single pulse via hits
    for (int d = N; d <= N + 3; d++) begin
      low_pwr = 1'b1; idle(4);
      exp_pulse($sformatf("R2 d=%0d", d), d, 1);
      check("R7 set", rxd_low, 1);
      to_normal();
    end

    // R6: already dominant at entry
    bus_rx = 1'b0; idle(4);
    low_pwr = 1'b1;
    h = 0;
    for (int k = 0; k < 4 * N; k++) begin
      @(negedge clk);
      if (wake_req) h++;
    end
    check("R6 no wake on held bus", h, 0);
    bus_rx = 1'b1; idle(4);
    exp_pulse("R6 fresh edge", N, 1);
    to_normal();

    // R8: leave low-power mid count, re-enter with bus still dominant
    low_pwr = 1'b1; idle(4);
    bus_rx = 1'b0;
    h = 0;
    for (int k = 1; k <= 3 * N; k++) begin
      @(negedge clk);
      if (wake_req) h++;
      if (k == N) low_pwr = 1'b0;
      if (k == N + 3) low_pwr = 1'b1;
    end
    check("R8 abort", h, 0);
    check("R8 rxd_low", rxd_low, 0);
    bus_rx = 1'b1; idle(4);
    low_pwr = 1'b0; idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule